// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit RISC core that runs in seven operating modes. Software addresses sixteen names: fifteen general registers and the program counter. The current mode decides which physical register stands behind each general name. Some names are backed by one register that every mode shares. Others have a private copy that only one mode sees. This lets an exception handler use its own stack pointer and link register, or a private r8–r14 in fast-interrupt mode, without saving the interrupted code's values first.

The store holds 37 physical 32-bit registers:

- 30 banked general registers
- the program counter
- the current status word
- five saved status words, one per exception mode

Two combinational read ports and one clocked write port take a 4-bit architectural index. The bank-selecting mode arrives on a 5-bit input. The program counter, the current status word and the saved status word each have a dedicated read value and write strobe. Forwarding and decode sit outside the block.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register and the program counter read zero. The current status word reads 0x000000D3: mode field 10011 in bits 4:0, IRQ mask bit 7 set, FIQ mask bit 6 set. Every saved status word is zero.
- R2: Indices 0–7 name one shared physical register each, the same in every mode.
- R3: In fast-interrupt mode, indices 8–14 reach a private set. Every other mode shares one set of indices 8–12.
- R4: Indices 13 and 14 have a private pair in each of the IRQ, supervisor, abort and undefined modes. User and system modes share one pair.
- R5: The mode encodings are user 10000, fast-interrupt 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other value selects the user-mode bank.
- R6: Both read ports are combinational. A write takes effect at the rising clock edge, into the physical register that the mode presented at that edge selects.
- R7: Index 15 on a read port returns the program counter. A general-port write to index 15 is ignored. The program counter changes only through its own write strobe.
- R8: Only bits 31:28 and 7:0 of a status word are stored. All other bits read as zero, whatever was written.
- R9: Each exception mode has its own saved status word. In user and system modes, the saved-status read returns the current status word, and a saved-status write has no effect.
- R10: When no write strobe is active, no stored value changes, even across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current mode encoding, selects the bank |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A value |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B value |
| wr_en | input | 1 | General write strobe |
| wr_idx | input | 4 | General write architectural index |
| wr_data | input | 32 | General write value |
| pc_wr_en | input | 1 | Program counter write strobe |
| pc_wr_data | input | 32 | Program counter write value |
| pc_o | output | 32 | Program counter |
| cpsr_wr_en | input | 1 | Current status write strobe |
| cpsr_wr_data | input | 32 | Current status write value |
| cpsr_o | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved status write strobe |
| spsr_wr_data | input | 32 | Saved status write value |
| spsr_o | output | 32 | Saved status of the current mode, or the current status in user/system mode |

## Verification
The assertions check the following on every cycle:

- a general write is visible one cycle later in the register it addressed
- storage holds still whenever no strobe is active
- a saved-status write in user or system mode leaves every saved word untouched
- index 15 always reads the program counter
- status writes keep only the implemented bits

Only the bench's scenarios can show that the index-to-register mapping is right as a whole: which names alias across modes and which are private. The bench writes a distinct value through every index in every mode, including an unlisted encoding. It then reads every index back in every mode and compares against its own ownership model.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int XLEN   = 32;
  localparam int NPHYS  = 30;
  localparam int NSPSR  = 5;
  localparam int PW     = $clog2(NPHYS);
  localparam int SW     = $clog2(NSPSR);
  localparam logic [XLEN-1:0] STATUS_MASK  = 32'hF000_00FF;
  localparam logic [XLEN-1:0] STATUS_RESET = 32'h0000_00D3;

  localparam logic [4:0] ENC_USR = 5'b10000;
  localparam logic [4:0] ENC_FIQ = 5'b10001;
  localparam logic [4:0] ENC_IRQ = 5'b10010;
  localparam logic [4:0] ENC_SVC = 5'b10011;
  localparam logic [4:0] ENC_ABT = 5'b10111;
  localparam logic [4:0] ENC_UND = 5'b11011;
  localparam logic [4:0] ENC_SYS = 5'b11111;

  typedef enum logic [2:0] {
    MK_USR = 3'd0, MK_FIQ = 3'd1, MK_IRQ = 3'd2, MK_SVC = 3'd3,
    MK_ABT = 3'd4, MK_UND = 3'd5, MK_SYS = 3'd6
  } mode_kind_t;

  function automatic mode_kind_t decode_mode(logic [4:0] enc);
    case (enc)
      ENC_FIQ: return MK_FIQ;
      ENC_IRQ: return MK_IRQ;
      ENC_SVC: return MK_SVC;
      ENC_ABT: return MK_ABT;
      ENC_UND: return MK_UND;
      ENC_SYS: return MK_SYS;
      default: return MK_USR;
    endcase
  endfunction

  // Physical layout: 0-7 shared, 8-12 user hi, 13-17 fiq hi,
  // 18/19 user sp/lr, then pairs for fiq, irq, svc, abt, und.
  function automatic logic [PW-1:0] phys_index(mode_kind_t k, logic [3:0] idx);
    logic [PW-1:0] base;
    if (idx == 4'd15) return '0;
    if (idx < 4'd8) return PW'(idx);
    if (idx < 4'd13) return (k == MK_FIQ) ? PW'(idx) + PW'(5) : PW'(idx);
    case (k)
      MK_FIQ:  base = PW'(20);
      MK_IRQ:  base = PW'(22);
      MK_SVC:  base = PW'(24);
      MK_ABT:  base = PW'(26);
      MK_UND:  base = PW'(28);
      default: base = PW'(18);
    endcase
    return base + PW'(idx - 4'd13);
  endfunction

  function automatic logic owns_spsr(mode_kind_t k);
    return (k != MK_USR) && (k != MK_SYS);
  endfunction

  function automatic logic [SW-1:0] spsr_slot(mode_kind_t k);
    return owns_spsr(k) ? SW'(k) - SW'(1) : '0;
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode_i,
  input  logic [3:0]    idx_a,
  input  logic [3:0]    idx_b,
  input  logic [3:0]    idx_w,
  output logic [PW-1:0] phys_a,
  output logic [PW-1:0] phys_b,
  output logic [PW-1:0] phys_w,
  output logic          spsr_valid,
  output logic [SW-1:0] spsr_sel
);
  mode_kind_t kind;

  always_comb begin
    kind       = decode_mode(mode_i);
    phys_a     = phys_index(kind, idx_a);
    phys_b     = phys_index(kind, idx_b);
    phys_w     = phys_index(kind, idx_w);
    spsr_valid = owns_spsr(kind);
    spsr_sel   = spsr_slot(kind);
  end

  assert_phys_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_a < PW'(NPHYS)) && (phys_w < PW'(NPHYS)));
  assert_spsr_slot_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_valid |-> (spsr_sel < SW'(NSPSR)));
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import bank_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NPHYS,
  parameter int A = PW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  logic [A-1:0] wr_phys,
  input  logic [W-1:0] wr_data,
  input  logic [A-1:0] rd_a_phys,
  input  logic [A-1:0] rd_b_phys,
  output logic [W-1:0] rd_a_data,
  output logic [W-1:0] rd_b_data
);
  logic [N-1:0][W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '0;
    else if (wr_fire) regs[wr_phys] <= wr_data;
  end

  assign rd_a_data = regs[rd_a_phys];
  assign rd_b_data = regs[rd_b_phys];

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> regs[$past(wr_phys)] == $past(wr_data));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(regs));
endmodule

// File: rtl/status_regs.sv
module status_regs
  import bank_pkg::*;
#(
  parameter int W = XLEN,
  parameter int S = NSPSR,
  parameter int B = SW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spsr_valid,
  input  logic [B-1:0] spsr_sel,
  input  logic         cpsr_we,
  input  logic [W-1:0] cpsr_wd,
  input  logic         spsr_we,
  input  logic [W-1:0] spsr_wd,
  output logic [W-1:0] cpsr_o,
  output logic [W-1:0] spsr_o
);
  logic [W-1:0]        cpsr_q;
  logic [S-1:0][W-1:0] spsr_q;
  logic                spsr_fire;

  assign spsr_fire = spsr_we && spsr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q <= STATUS_RESET;
      spsr_q <= '0;
    end else begin
      if (cpsr_we)   cpsr_q           <= cpsr_wd & STATUS_MASK;
      if (spsr_fire) spsr_q[spsr_sel] <= spsr_wd & STATUS_MASK;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = spsr_valid ? spsr_q[spsr_sel] : cpsr_q;

  assert_cpsr_masked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |=> cpsr_o == ($past(cpsr_wd) & STATUS_MASK));
  assert_spsr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spsr_we && !spsr_valid) |=> $stable(spsr_q));
  assert_spsr_alias_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spsr_valid |-> spsr_o == cpsr_o);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  mode_i,
  input  logic [3:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        pc_wr_en,
  input  logic [31:0] pc_wr_data,
  output logic [31:0] pc_o,
  input  logic        cpsr_wr_en,
  input  logic [31:0] cpsr_wr_data,
  output logic [31:0] cpsr_o,
  input  logic        spsr_wr_en,
  input  logic [31:0] spsr_wr_data,
  output logic [31:0] spsr_o
);
  localparam logic [3:0] PC_IDX = 4'd15;

  logic [PW-1:0]   phys_a, phys_b, phys_w;
  logic            spsr_valid;
  logic [SW-1:0]   spsr_sel;
  logic [XLEN-1:0] gpr_a, gpr_b;
  logic [XLEN-1:0] pc_q;
  logic            gpr_wr_fire;
  logic            pc_idx_write;

  assign pc_idx_write = wr_en && (wr_idx == PC_IDX);
  assign gpr_wr_fire  = wr_en && !pc_idx_write;

  bank_map map_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .idx_a(rd_a_idx), .idx_b(rd_b_idx), .idx_w(wr_idx),
    .phys_a(phys_a), .phys_b(phys_b), .phys_w(phys_w),
    .spsr_valid(spsr_valid), .spsr_sel(spsr_sel)
  );

  gpr_store store_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(gpr_wr_fire), .wr_phys(phys_w),
    .wr_data(wr_data), .rd_a_phys(phys_a), .rd_b_phys(phys_b),
    .rd_a_data(gpr_a), .rd_b_data(gpr_b)
  );

  status_regs status_i (
    .clk(clk), .rst_n(rst_n), .spsr_valid(spsr_valid), .spsr_sel(spsr_sel),
    .cpsr_we(cpsr_wr_en), .cpsr_wd(cpsr_wr_data),
    .spsr_we(spsr_wr_en), .spsr_wd(spsr_wr_data),
    .cpsr_o(cpsr_o), .spsr_o(spsr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (pc_wr_en) pc_q <= pc_wr_data;
  end

  assign pc_o      = pc_q;
  assign rd_a_data = (rd_a_idx == PC_IDX) ? pc_q : gpr_a;
  assign rd_b_data = (rd_b_idx == PC_IDX) ? pc_q : gpr_b;

  assert_idx15_reads_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == PC_IDX) |-> rd_a_data == pc_o);
  assert_pc_only_own_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_wr_en |=> $stable(pc_o));
  assert_pc_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> pc_o == $past(pc_wr_data));
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, pc_o, cpsr_o, spsr_o;
  logic        wr_en = 1'b0, pc_wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0;
  logic [31:0] wr_data = '0, pc_wr_data = '0, cpsr_wr_data = '0, spsr_wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  banked_regfile dut_i (.*);

  // Mode table: seven listed encodings plus one unlisted value.
  localparam logic [4:0] ENCS [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                      5'b10111, 5'b11011, 5'b11111, 5'b01010};
  localparam int KIND [8] = '{0, 1, 2, 3, 4, 5, 6, 0};

  logic [31:0] model [128];
  logic [31:0] model_pc;
  logic [31:0] model_cpsr;
  logic [31:0] model_spsr [8];

  // Who owns (mode kind m, index i): 7 = shared by all, else a kind number.
  function automatic int owner(int m, int i);
    if (i < 8) return 7;
    if (i < 13) return (m == 1) ? 1 : 0;
    return (m == 6) ? 0 : m;
  endfunction

  function automatic logic [31:0] expect_read(int m, int i);
    if (i == 15) return model_pc;
    return model[owner(m, i) * 16 + i];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gpr_write(int e, int i, logic [31:0] d);
    @(negedge clk);
    mode_i = ENCS[e]; wr_idx = 4'(i); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (i != 15) model[owner(KIND[e], i) * 16 + i] = d;
  endtask

  task automatic sweep_reads(string req);
    for (int e = 0; e < 8; e++) begin
      for (int i = 0; i < 16; i++) begin
        mode_i = ENCS[e]; rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
        #1;
        chk(req, rd_a_data, expect_read(KIND[e], i));
        chk(req, rd_b_data, expect_read(KIND[e], 15 - i));
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 128; k++) model[k] = '0;
    for (int k = 0; k < 8; k++) model_spsr[k] = '0;
    model_pc = '0;
    model_cpsr = 32'h0000_00D3;
    #20;
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state everywhere
    sweep_reads("R1");
    chk("R1", cpsr_o, 32'h0000_00D3);
    chk("R1", pc_o, 32'h0);
    for (int e = 1; e < 6; e++) begin
      mode_i = ENCS[e]; #1; chk("R1", spsr_o, 32'h0);
    end

    // R2/R3/R4/R5/R6: write every index in every mode, then read all back
    for (int pass = 0; pass < 2; pass++) begin
      for (int e = 0; e < 8; e++)
        for (int i = 0; i < 15; i++)
          gpr_write(e, i, 32'hC000_0000 | (pass << 16) | (e << 8) | i);
      sweep_reads(pass == 0 ? "R2_R3_R4_R5" : "R6");
    end

    // R6: read port follows index change without a clock
    mode_i = ENCS[2]; rd_a_idx = 4'd13; #1;
    chk("R6", rd_a_data, expect_read(2, 13));
    rd_a_idx = 4'd14; #1;
    chk("R6", rd_a_data, expect_read(2, 14));

    // R7: general write to index 15 ignored; PC via own strobe
    gpr_write(3, 15, 32'hDEAD_BEEF);
    chk("R7", pc_o, model_pc);
    @(negedge clk); pc_wr_data = 32'h0000_1234; pc_wr_en = 1'b1;
    @(negedge clk); pc_wr_en = 1'b0; model_pc = 32'h0000_1234;
    chk("R7", pc_o, 32'h0000_1234);
    sweep_reads("R7");

    // R8: unimplemented status bits read zero
    @(negedge clk); cpsr_wr_data = 32'hFFFF_FFFF; cpsr_wr_en = 1'b1;
    @(negedge clk); cpsr_wr_en = 1'b0;
    chk("R8", cpsr_o, 32'hF000_00FF);
    @(negedge clk); cpsr_wr_data = 32'h5A5A_5A1F; cpsr_wr_en = 1'b1;
    @(negedge clk); cpsr_wr_en = 1'b0; model_cpsr = 32'h5000_001F;
    chk("R8", cpsr_o, model_cpsr);

    // R9: one saved status per exception mode
    for (int e = 1; e < 6; e++) begin
      @(negedge clk); mode_i = ENCS[e];
      spsr_wr_data = 32'h0FFF_FF00 | (e << 28) | (e * 17); spsr_wr_en = 1'b1;
      @(negedge clk); spsr_wr_en = 1'b0;
      model_spsr[e] = (32'h0FFF_FF00 | (e << 28) | (e * 17)) & 32'hF000_00FF;
    end
    for (int e = 0; e < 8; e++) begin
      @(negedge clk); mode_i = ENCS[e];
      spsr_wr_data = 32'hFFFF_FFFF; spsr_wr_en = (KIND[e] == 0 || KIND[e] == 6);
      #1;
      if (KIND[e] == 0 || KIND[e] == 6) chk("R9", spsr_o, model_cpsr);
      @(negedge clk); spsr_wr_en = 1'b0;
    end
    for (int e = 1; e < 6; e++) begin
      mode_i = ENCS[e]; #1; chk("R9", spsr_o, model_spsr[e]);
    end
    chk("R9", cpsr_o, model_cpsr);

    // R10: idle cycles with mode changes leave everything alone
    for (int e = 0; e < 8; e++) begin
      @(negedge clk); mode_i = ENCS[e];
    end
    repeat (3) @(negedge clk);
    sweep_reads("R10");
    chk("R10", cpsr_o, model_cpsr);

    finish_run();
  end
endmodule